// File: doc/BRIEF.md
# Conversion Result Range Guard

This block sits beside a data converter's result path and watches each result as it completes. Every valid result carries a channel number and a 12-bit value. The block compares the value with a programmed window made of a low bound and a high bound. The bounds come from the low 12 bits of two 16-bit threshold registers. A value outside the window raises a flag. The flag stays raised until software removes it.

Software picks one guarded channel with a 5-bit select. It can also ask for every channel to be guarded. An interrupt request follows the flag whenever the interrupt enable is 1. The comparison always uses the raw right-aligned 12-bit result. Data alignment, bus decoding and the conversion itself belong to other blocks.

Top module: `range_guard`

## Requirements
- R1: After a synchronous reset, `event_flag` and `irq` are both 0.
- R2: A checked result whose value is below `lo_thr_reg[11:0]` sets `event_flag` at the next rising clock edge.
- R3: A checked result whose value is above `hi_thr_reg[11:0]` sets `event_flag` at the next rising clock edge.
- R4: A checked result whose value equals either bound, or lies between them, does not set `event_flag`.
- R5: Bits 15:12 of both threshold registers have no effect on the comparison.
- R6: When `guard_all` is 0, only results whose `res_chan` equals `guard_sel` are checked. Results from other channels leave `event_flag` unchanged.
- R7: When `guard_all` is 1, results from every channel are checked.
- R8: Only `guard_sel` codes 0 to 17 name a channel. When `guard_all` is 0 and `guard_sel` is 18 or more, no result is checked.
- R9: Once set, `event_flag` stays 1 until `flag_clear` is 1 at a rising edge. It then reads 0 after that edge, unless R10 applies.
- R10: If a result sets the flag in the same cycle as `flag_clear` is 1, the flag is 1 after that edge.
- R11: `irq` is 1 in exactly those cycles in which `event_flag` is 1 and `irq_en` is 1. It follows `irq_en` within the same cycle.
- R12: In a cycle with `res_valid` at 0, the result inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| res_valid | input | 1 | Result-valid strobe, one cycle per result |
| res_chan | input | 5 | Channel number of the result |
| res_value | input | 12 | Raw right-aligned result value |
| lo_thr_reg | input | 16 | Low threshold register; bits 11:0 are used |
| hi_thr_reg | input | 16 | High threshold register; bits 11:0 are used |
| guard_sel | input | 5 | Guarded channel select, codes 0 to 17 |
| guard_all | input | 1 | 1 = check results from every channel |
| irq_en | input | 1 | Interrupt enable for the range event |
| flag_clear | input | 1 | Software clear of the event flag |
| event_flag | output | 1 | Sticky out-of-range flag |
| irq | output | 1 | Interrupt request |

## Verification
Two things can arrive in the same cycle: a hardware set from an out-of-window result, and a software clear. The bench provokes this in two states. In one, the flag is already set. In the other, the flag is clear. In both, it drives an out-of-range result together with `flag_clear` in one cycle. The scoreboard model applies the set-over-clear rule on its own terms and expects the flag to read 1 after that edge. It also expects a plain clear with no result to drop the flag.

// File: rtl/range_guard_pkg.sv
package range_guard_pkg;

    localparam int VAL_W     = 12;
    localparam int THR_REG_W = 16;
    localparam int CHAN_W    = 5;
    localparam int NUM_CHAN  = 18;

    typedef struct packed {
        logic              valid;
        logic [CHAN_W-1:0] chan;
        logic [VAL_W-1:0]  value;
    } sample_t;

    typedef struct packed {
        logic [VAL_W-1:0] lo;
        logic [VAL_W-1:0] hi;
    } window_t;

    typedef enum logic [1:0] {
        ZONE_INSIDE = 2'd0,
        ZONE_BELOW  = 2'd1,
        ZONE_ABOVE  = 2'd2
    } zone_e;

    // Only the low VAL_W bits of each threshold register form the window.
    function automatic window_t take_window(
        input logic [THR_REG_W-1:0] lo_reg,
        input logic [THR_REG_W-1:0] hi_reg
    );
        window_t w;
        w.lo = lo_reg[VAL_W-1:0];
        w.hi = hi_reg[VAL_W-1:0];
        return w;
    endfunction

    function automatic zone_e classify(
        input logic [VAL_W-1:0] v,
        input window_t          w
    );
        if (v < w.lo)      return ZONE_BELOW;
        else if (v > w.hi) return ZONE_ABOVE;
        else               return ZONE_INSIDE;
    endfunction

endpackage

// File: rtl/rg_chan_filter.sv
module rg_chan_filter
    import range_guard_pkg::*;
#(
    parameter int N_CHAN = NUM_CHAN
) (
    input  sample_t           smp_in,
    input  logic              guard_all,
    input  logic [CHAN_W-1:0] guard_sel,
    output sample_t           smp_out
);
    localparam logic [CHAN_W-1:0] LAST_CODE = CHAN_W'(N_CHAN - 1);

    logic sel_legal;
    logic chan_hit;

    always_comb begin
        sel_legal = (guard_sel <= LAST_CODE);
        chan_hit  = guard_all || (sel_legal && (smp_in.chan == guard_sel));
        smp_out       = smp_in;
        smp_out.valid = smp_in.valid && chan_hit;
    end
endmodule

// File: rtl/rg_window_cmp.sv
module rg_window_cmp
    import range_guard_pkg::*;
(
    input  sample_t smp,
    input  window_t win,
    output logic    out_of_range
);
    zone_e zone;

    always_comb begin
        zone         = classify(smp.value, win);
        out_of_range = smp.valid && (zone != ZONE_INSIDE);
    end
endmodule

// File: rtl/rg_sticky_flag.sv
module rg_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_req) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    // R9: without a clear, a raised flag holds
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        flag && !clr_req |=> flag);

    // R9: a clear with no set drops the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clr_req && !set_req |=> !flag);

    // R10: a set always lands, even with a clear in the same cycle
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_req |=> flag);
endmodule

// File: rtl/range_guard.sv
module range_guard
    import range_guard_pkg::*;
#(
    parameter int N_CHAN = NUM_CHAN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 res_valid,
    input  logic [CHAN_W-1:0]    res_chan,
    input  logic [VAL_W-1:0]     res_value,
    input  logic [THR_REG_W-1:0] lo_thr_reg,
    input  logic [THR_REG_W-1:0] hi_thr_reg,
    input  logic [CHAN_W-1:0]    guard_sel,
    input  logic                 guard_all,
    input  logic                 irq_en,
    input  logic                 flag_clear,
    output logic                 event_flag,
    output logic                 irq
);
    sample_t smp_raw;
    sample_t smp_checked;
    window_t win;
    logic    out_of_range;
    logic    unused_thr_upper;

    assign smp_raw          = '{valid: res_valid, chan: res_chan, value: res_value};
    assign win              = take_window(lo_thr_reg, hi_thr_reg);
    assign unused_thr_upper = ^{lo_thr_reg[THR_REG_W-1:VAL_W], hi_thr_reg[THR_REG_W-1:VAL_W]};

    rg_chan_filter #(.N_CHAN(N_CHAN)) u_filter (
        .smp_in    (smp_raw),
        .guard_all (guard_all),
        .guard_sel (guard_sel),
        .smp_out   (smp_checked)
    );

    rg_window_cmp u_cmp (
        .smp          (smp_checked),
        .win          (win),
        .out_of_range (out_of_range)
    );

    rg_sticky_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_req (out_of_range),
        .clr_req (flag_clear),
        .flag    (event_flag)
    );

    assign irq = event_flag && irq_en;

    // R2: guarded result below the low bound raises the flag at the next edge
    a_r2_below_sets: assert property (@(posedge clk) disable iff (rst)
        res_valid && guard_all && (res_value < lo_thr_reg[VAL_W-1:0]) |=> event_flag);

    // R3: guarded result above the high bound raises the flag at the next edge
    a_r3_above_sets: assert property (@(posedge clk) disable iff (rst)
        res_valid && guard_all && (res_value > hi_thr_reg[VAL_W-1:0]) |=> event_flag);

    // R12: with no valid result and no clear, the flag does not move
    a_r12_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !res_valid && !flag_clear |=> $stable(event_flag));
endmodule

// File: tb/range_guard_bench.sv
module range_guard_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        res_valid;
    logic [4:0]  res_chan;
    logic [11:0] res_value;
    logic [15:0] lo_thr_reg;
    logic [15:0] hi_thr_reg;
    logic [4:0]  guard_sel;
    logic        guard_all;
    logic        irq_en;
    logic        flag_clear;
    logic        event_flag;
    logic        irq;

    always #10 clk = ~clk; // 50 MHz

    range_guard u_range_guard (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_chan(res_chan),
        .res_value(res_value), .lo_thr_reg(lo_thr_reg), .hi_thr_reg(hi_thr_reg),
        .guard_sel(guard_sel), .guard_all(guard_all), .irq_en(irq_en),
        .flag_clear(flag_clear), .event_flag(event_flag), .irq(irq)
    );

    typedef struct {
        string tag;
        bit    exp_flag;
        bit    exp_irq;
    } item_t;

    item_t queue_q[$];
    int    n_cmp  = 0;
    int    n_bad  = 0;
    bit    model_flag = 1'b0;
    bit    done = 1'b0;

    // Driver: apply one cycle of stimulus and push the expected outcome.
    task automatic step(input string tag, input bit v, input logic [4:0] ch,
                        input logic [11:0] val, input bit clr);
        item_t it;
        bit checked, hit;
        @(negedge clk);
        res_valid  = v;
        res_chan   = ch;
        res_value  = val;
        flag_clear = clr;
        checked = v && (guard_all || (guard_sel < 5'd18 && guard_sel == ch));
        hit = checked && (val < lo_thr_reg[11:0] || val > hi_thr_reg[11:0]);
        model_flag = hit || (model_flag && !clr);
        it.tag      = tag;
        it.exp_flag = model_flag;
        it.exp_irq  = model_flag && irq_en;
        queue_q.push_back(it);
    endtask

    // Monitor: compare a little after each rising edge.
    always @(posedge clk) begin
        #5;
        if (queue_q.size() > 0) begin
            item_t it;
            it = queue_q.pop_front();
            n_cmp++;
            if (event_flag !== it.exp_flag || irq !== it.exp_irq) begin
                n_bad++;
                $display("FAIL %s: flag/irq actual %b/%b expected %b/%b",
                         it.tag, event_flag, irq, it.exp_flag, it.exp_irq);
            end
        end
    end

    initial begin
        rst = 1'b1; res_valid = 0; res_chan = 0; res_value = 0;
        lo_thr_reg = 16'h0100; hi_thr_reg = 16'h0E00;
        guard_sel = 5'd3; guard_all = 0; irq_en = 1; flag_clear = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        n_cmp++;
        if (event_flag !== 1'b0 || irq !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: flag/irq actual %b/%b expected 0/0", event_flag, irq);
        end
        step("R4 equal low",   1, 5'd3, 12'h100, 0);
        step("R4 equal high",  1, 5'd3, 12'hE00, 0);
        step("R4 inside",      1, 5'd3, 12'h800, 0);
        step("R12 no valid",   0, 5'd3, 12'h000, 0);
        step("R2 below",       1, 5'd3, 12'h0FF, 0);
        step("R9 sticky",      0, 5'd0, 12'h000, 0);
        @(negedge clk); irq_en = 0;
        step("R11 irq off",    0, 5'd0, 12'h000, 0);
        @(negedge clk); irq_en = 1;
        step("R11 irq on",     0, 5'd0, 12'h000, 0);
        step("R9 clear",       0, 5'd0, 12'h000, 1);
        step("R3 above",       1, 5'd3, 12'hE01, 0);
        step("R9 clear again", 0, 5'd0, 12'h000, 1);
        step("R6 other chan",  1, 5'd5, 12'hFFF, 0);
        @(negedge clk); guard_all = 1;
        step("R7 any chan",    1, 5'd5, 12'hFFF, 0);
        step("R10 set with clear, flag set", 1, 5'd9, 12'h000, 1);
        step("R9 clear after R10", 0, 5'd0, 12'h000, 1);
        step("R10 set with clear, flag idle", 1, 5'd1, 12'hFFF, 1);
        step("R9 clear",       0, 5'd0, 12'h000, 1);
        @(negedge clk); guard_all = 0; guard_sel = 5'd20;
        step("R8 illegal sel", 1, 5'd20, 12'h000, 0);
        step("R8 illegal sel other", 1, 5'd3, 12'hFFF, 0);
        @(negedge clk); guard_sel = 5'd17;
        step("R8 top legal sel", 1, 5'd17, 12'h000, 0);
        step("R9 clear",       0, 5'd0, 12'h000, 1);
        @(negedge clk); lo_thr_reg = 16'hA100; hi_thr_reg = 16'h5E00;
        step("R5 upper bits low",  1, 5'd17, 12'h200, 0);
        step("R5 upper bits high", 1, 5'd17, 12'hF00, 0);
        step("R12 no valid hold",  0, 5'd17, 12'h000, 0);
        step("R9 final clear",     0, 5'd0, 12'h000, 1);
        @(negedge clk); res_valid = 0; flag_clear = 0;
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule